// File: doc/BRIEF.md
# I2C SCL Timing Generator with Dual-Speed Counts

This block produces the serial clock (SCL) for an I2C master together with a one-cycle strobe that marks when the receive path should sample SDA. A programmable pre-divider first turns the system clock into a tick stream. Two nested counters then measure each SCL half-period. The inner counter runs for `sample` ticks, and each time it wraps the outer counter advances one step. A half-period ends when the outer counter has made `step` steps. One half-period therefore lasts `prediv_ratio × sample × step` system cycles, and a full SCL period is twice that.

Two timing words feed the counters. The standard word covers standard and fast mode. The high-speed word holds its own counts and an enable field. When the enable field reads 3, a pulse on `hs_switch` (issued by the master once the master-code preamble is done) moves the counters onto the high-speed counts at the next half-period boundary. All configuration inputs are copied into shadow registers only while the bus is idle, so a running SCL never changes length part-way through a phase.

The control machine has three states. **PH_IDLE** holds SCL high and reloads the shadows. **PH_LOW** drives SCL low. **PH_HIGH** releases SCL high. The transitions are:
- *start*: PH_IDLE to PH_LOW when `run` is sampled high.
- *rise*: PH_LOW to PH_HIGH at the end of a half-period.
- *fall*: PH_HIGH to PH_LOW at the end of a half-period while `run` is high.
- *park*: PH_HIGH to PH_IDLE at the end of a half-period while `run` is low.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, `scl_o` is 1, `sample_stb` is 0 and `hs_active` is 0.
- R2: Each SCL low phase and each SCL high phase lasts D×S×T system cycles, where D is the pre-divider ratio, S is the sample count and T is the step count. SCL goes low on the first clock edge that samples `run` high in idle.
- R3: In `cfg_timing`, bits [5:0] hold T−1 (T from 1 to 64) and bits [10:8] hold S−1 (S from 1 to 8). All other bits are ignored.
- R4: `cfg_prediv` holds D−1, giving a ratio from 1 to 256. A value of 0 produces a tick on every cycle.
- R5: `sample_stb` is asserted for exactly one cycle in each high phase, at cycle ((T>>1)×S+1)×D−1, counted from the first cycle of that high phase (cycle 0).
- R6: When `run` is low at the end of a high phase, SCL stays high and no further strobes occur until `run` is sampled high again.
- R7: If `cfg_hs[1:0]` is 3, a `hs_switch` pulse during a running bus makes every later half-period use the high-speed counts: T−1 from `cfg_hs[10:8]` and S−1 from `cfg_hs[14:12]`. The pre-divider stays the same. `hs_active` reads 1 from the first such half-period.
- R8: If `cfg_hs[1:0]` is not 3 (a value of 0 included), or if the bus is idle, `hs_switch` has no effect. Timing stays on the standard counts and `hs_active` stays 0.
- R9: Changes to `cfg_timing`, `cfg_hs` or `cfg_prediv` while the bus runs have no effect until the bus has returned to idle.
- R10: The switch to high-speed counts happens only at a half-period boundary. The phase in which `hs_switch` arrives completes with the old counts. A pulse sampled in the last cycle of a phase takes effect at the boundary after the next one.
- R11: On the park transition, `hs_active` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Keep SCL toggling while high |
| hs_switch | input | 1 | One-cycle pulse: master-code phase done, move to high-speed counts |
| cfg_timing | input | 16 | Standard/fast counts: T−1 in [5:0], S−1 in [10:8] |
| cfg_hs | input | 16 | High-speed word: enable in [1:0] (3 = on), T−1 in [10:8], S−1 in [14:12] |
| cfg_prediv | input | 8 | Pre-divider ratio minus one |
| scl_o | output | 1 | Serial clock level |
| sample_stb | output | 1 | One-cycle strobe at the middle of each SCL high phase |
| hs_active | output | 1 | High-speed counts in use |

## Verification
The close race is between the end of a half-period and the arrival of `hs_switch`. Both can land in the same cycle, so the block must decide whether the new counts belong to the next phase or to the one after it. The bench provokes this by counting from the start of a low phase and raising the pulse exactly in that phase's final cycle. It then checks that the following high phase still measures the standard length with `hs_active` at 0, and that the low phase after it has the high-speed length with `hs_active` at 1. A second case sends the pulse early in a phase, and the bench checks that the phase still ends at its standard length.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;

    // Field positions decoded from the timing words
    localparam int STD_STEP_LSB = 0;
    localparam int STD_SAMP_LSB = 8;
    localparam int HS_EN_LSB    = 0;
    localparam int HS_STEP_LSB  = 8;
    localparam int HS_SAMP_LSB  = 12;
    localparam logic [1:0] HS_EN_CODE = 2'b11;

endpackage

// File: rtl/scl_prescale.sv
module scl_prescale #(
    parameter int PDIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [PDIV_W-1:0] lim,
    output logic              ce
);

    logic [PDIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || cnt_q == lim) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        ce = !clr && (cnt_q == lim);
    end

    AST_PRE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q <= lim)) else $error("prescaler overran its limit"); // R4

endmodule

// File: rtl/scl_tick_nest.sv
module scl_tick_nest #(
    parameter int STEP_W = 6,
    parameter int SAMP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ce,
    input  logic [STEP_W-1:0] step_lim,
    input  logic [SAMP_W-1:0] samp_lim,
    output logic [STEP_W-1:0] step_idx,
    output logic [SAMP_W-1:0] samp_idx,
    output logic              span_done
);

    logic samp_wrap;

    always_comb begin
        samp_wrap = (samp_idx == samp_lim);
        span_done = ce && samp_wrap && (step_idx == step_lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_idx <= '0;
            samp_idx <= '0;
        end else if (clr) begin
            step_idx <= '0;
            samp_idx <= '0;
        end else if (ce) begin
            if (samp_wrap) begin
                samp_idx <= '0;
                step_idx <= (step_idx == step_lim) ? '0 : step_idx + 1'b1;
            end else begin
                samp_idx <= samp_idx + 1'b1;
            end
        end
    end

    AST_SPAN_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        span_done |=> (step_idx == '0) && (samp_idx == '0)) else $error("span did not restart"); // R2

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
    parameter int REG_W     = 16,
    parameter int PDIV_W    = 8,
    parameter int STEP_W    = 6,
    parameter int SAMP_W    = 3,
    parameter int HS_STEP_W = 3,
    parameter int HS_SAMP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              hs_switch,
    input  logic [REG_W-1:0]  cfg_timing,
    input  logic [REG_W-1:0]  cfg_hs,
    input  logic [PDIV_W-1:0] cfg_prediv,
    output logic              scl_o,
    output logic              sample_stb,
    output logic              hs_active
);
    import i2c_scl_pkg::*;

    localparam int MID_W = STEP_W + 1;

    phase_t ph_q, ph_d;

    logic [STEP_W-1:0]    step_lim;
    logic [SAMP_W-1:0]    samp_lim;
    logic [HS_STEP_W-1:0] hs_step_sh;
    logic [HS_SAMP_W-1:0] hs_samp_sh;
    logic                 hs_en_sh;
    logic [PDIV_W-1:0]    pre_lim;
    logic                 hs_pend;
    logic                 hs_on_q;

    logic              idle;
    logic              ce;
    logic              half_end;
    logic [STEP_W-1:0] step_idx;
    logic [SAMP_W-1:0] samp_idx;
    logic [MID_W-1:0]  mid_step;
    logic              unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_timing, cfg_hs};

    always_comb begin
        idle = (ph_q == PH_IDLE);
    end

    scl_prescale #(.PDIV_W(PDIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idle),
        .lim   (pre_lim),
        .ce    (ce)
    );

    scl_tick_nest #(.STEP_W(STEP_W), .SAMP_W(SAMP_W)) u_nest (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (idle),
        .ce        (ce),
        .step_lim  (step_lim),
        .samp_lim  (samp_lim),
        .step_idx  (step_idx),
        .samp_idx  (samp_idx),
        .span_done (half_end)
    );

    // Next-phase decision
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE: if (run)      ph_d = PH_LOW;                       // start
            PH_LOW:  if (half_end) ph_d = PH_HIGH;                      // rise
            PH_HIGH: if (half_end) ph_d = run ? PH_LOW : PH_IDLE;       // fall / park
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // Shadow loading and high-speed switch-over
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_lim   <= '0;
            samp_lim   <= '0;
            hs_step_sh <= '0;
            hs_samp_sh <= '0;
            hs_en_sh   <= 1'b0;
            pre_lim    <= '0;
            hs_pend    <= 1'b0;
            hs_on_q    <= 1'b0;
        end else if (idle) begin
            step_lim   <= cfg_timing[STD_STEP_LSB +: STEP_W];
            samp_lim   <= cfg_timing[STD_SAMP_LSB +: SAMP_W];
            hs_step_sh <= cfg_hs[HS_STEP_LSB +: HS_STEP_W];
            hs_samp_sh <= cfg_hs[HS_SAMP_LSB +: HS_SAMP_W];
            hs_en_sh   <= (cfg_hs[HS_EN_LSB +: 2] == HS_EN_CODE);
            pre_lim    <= cfg_prediv;
            hs_pend    <= 1'b0;
            hs_on_q    <= 1'b0;
        end else if (half_end && ph_q == PH_HIGH && !run) begin
            hs_pend <= 1'b0;
            hs_on_q <= 1'b0;
        end else if (half_end && hs_pend) begin
            step_lim <= STEP_W'(hs_step_sh);
            samp_lim <= SAMP_W'(hs_samp_sh);
            hs_pend  <= 1'b0;
            hs_on_q  <= 1'b1;
        end else if (hs_switch && hs_en_sh && !hs_on_q) begin
            hs_pend <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        mid_step   = MID_W'((MID_W'(step_lim) + 1'b1) >> 1);
        scl_o      = (ph_q != PH_LOW);
        sample_stb = (ph_q == PH_HIGH) && ce &&
                     (MID_W'(step_idx) == mid_step) && (samp_idx == '0);
        hs_active  = hs_on_q;
    end

    AST_SCL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !half_end) |=> $stable(scl_o)) else $error("SCL moved mid-phase"); // R2
    AST_LIM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !half_end) |=> ($stable(step_lim) && $stable(samp_lim))) else $error("counts reloaded mid-phase"); // R9
    AST_STB_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> scl_o) else $error("strobe outside high phase"); // R5
    AST_STB_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb) else $error("strobe wider than one cycle"); // R5
    AST_HS_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_active) |-> $past(half_end)) else $error("high-speed switch off boundary"); // R10
    AST_HS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        hs_active |-> hs_en_sh) else $error("high-speed without enable code"); // R8

endmodule

// File: tb/i2c_scl_timer_test.sv
`timescale 1ns/1ps
module i2c_scl_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        hs_switch = 1'b0;
    logic [15:0] cfg_timing = 16'h0000;
    logic [15:0] cfg_hs = 16'h0000;
    logic [7:0]  cfg_prediv = 8'h00;
    logic        scl_o, sample_stb, hs_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_scl_timer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .hs_switch  (hs_switch),
        .cfg_timing (cfg_timing),
        .cfg_hs     (cfg_hs),
        .cfg_prediv (cfg_prediv),
        .scl_o      (scl_o),
        .sample_stb (sample_stb),
        .hs_active  (hs_active)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Count negedges while scl_o stays at lvl (bounded by lim); record strobe offset.
    task automatic phase_len(input bit lvl, input int lim, output int n, output int stb_at, output int stb_cnt);
        n = 0; stb_at = -1; stb_cnt = 0;
        while (scl_o == lvl && n < lim) begin
            if (sample_stb) begin
                if (stb_at < 0) stb_at = n;
                stb_cnt++;
            end
            @(negedge clk);
            n++;
        end
    endtask

    task automatic start_bus(input string req);
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        chk(req, "scl low after start", scl_o, 0);
    endtask

    // Called at low offset 0: drop run, finish low, then confirm SCL parks high.
    task automatic stop_bus(input int exp_low);
        int n, s, c;
        run = 1'b0;
        phase_len(1'b0, 4000, n, s, c);
        chk("R6", "last low length", n, exp_low);
        phase_len(1'b1, 2 * exp_low + 1200, n, s, c);
        chk("R6", "scl parked high", n, 2 * exp_low + 1200);
        chk("R11", "hs_active after park", hs_active, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "scl in reset", scl_o, 1);
        chk("R1", "stb in reset", sample_stb, 0);
        chk("R1", "hs_active in reset", hs_active, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "scl idle after reset", scl_o, 1);
    endtask

    task automatic t_run(input string tag, input logic [15:0] tm, input logic [7:0] pd,
                         input int exp_h, input int exp_stb);
        int n, s, c;
        cfg_timing = tm; cfg_prediv = pd; cfg_hs = 16'h0000;
        start_bus("R2");
        phase_len(1'b0, 4000, n, s, c);
        chk("R2", {tag, " low length"}, n, exp_h);
        phase_len(1'b1, 4000, n, s, c);
        chk("R2", {tag, " high length"}, n, exp_h);
        chk("R5", {tag, " strobe offset"}, s, exp_stb);
        chk("R5", {tag, " strobe count"}, c, 1);
        stop_bus(exp_h);
    endtask

    task automatic t_freeze();
        int n, s, c;
        cfg_timing = 16'h0204; cfg_prediv = 8'd1;
        start_bus("R9");
        cfg_timing = 16'h0000; cfg_prediv = 8'd0; cfg_hs = 16'h1203;
        phase_len(1'b0, 4000, n, s, c);
        chk("R9", "low keeps old counts", n, 30);
        phase_len(1'b1, 4000, n, s, c);
        chk("R9", "high keeps old counts", n, 30);
        stop_bus(30);
        cfg_hs = 16'h0000;
        start_bus("R9");
        phase_len(1'b0, 4000, n, s, c);
        chk("R9", "new counts after idle", n, 1);
        phase_len(1'b1, 4000, n, s, c);
        stop_bus(1);
    endtask

    task automatic t_hs();
        int n, s, c;
        cfg_timing = 16'h0204; cfg_prediv = 8'd1; cfg_hs = 16'h1203;
        start_bus("R7");
        hs_switch = 1'b1;
        @(negedge clk);
        hs_switch = 1'b0;
        phase_len(1'b0, 4000, n, s, c);
        chk("R10", "phase with pulse keeps std length", n, 29);
        chk("R7", "hs_active at first hs phase", hs_active, 1);
        phase_len(1'b1, 4000, n, s, c);
        chk("R7", "hs high length", n, 12);
        chk("R7", "hs strobe offset", s, 5);
        stop_bus(12);
    endtask

    task automatic t_hs_off(input logic [15:0] hsw);
        int n, s, c;
        cfg_timing = 16'h0204; cfg_prediv = 8'd1; cfg_hs = hsw;
        start_bus("R8");
        hs_switch = 1'b1;
        @(negedge clk);
        hs_switch = 1'b0;
        phase_len(1'b0, 4000, n, s, c);
        chk("R8", "low length without enable", n, 29);
        phase_len(1'b1, 4000, n, s, c);
        chk("R8", "high stays std", n, 30);
        chk("R8", "hs_active stays low", hs_active, 0);
        stop_bus(30);
    endtask

    task automatic t_hs_idle();
        int n, s, c;
        cfg_timing = 16'h0204; cfg_prediv = 8'd1; cfg_hs = 16'h1203;
        @(negedge clk);
        hs_switch = 1'b1;
        @(negedge clk);
        hs_switch = 1'b0;
        start_bus("R8");
        phase_len(1'b0, 4000, n, s, c);
        chk("R8", "idle pulse ignored low", n, 30);
        phase_len(1'b1, 4000, n, s, c);
        chk("R8", "idle pulse ignored high", n, 30);
        chk("R8", "idle pulse hs_active", hs_active, 0);
        stop_bus(30);
    endtask

    task automatic t_boundary();
        int n, s, c;
        cfg_timing = 16'h0204; cfg_prediv = 8'd1; cfg_hs = 16'h1203;
        start_bus("R10");
        repeat (29) @(negedge clk);
        hs_switch = 1'b1;
        @(negedge clk);
        hs_switch = 1'b0;
        chk("R10", "rise on boundary cycle", scl_o, 1);
        chk("R10", "hs_active not yet", hs_active, 0);
        phase_len(1'b1, 4000, n, s, c);
        chk("R10", "high after boundary pulse std", n, 30);
        chk("R10", "hs_active one phase later", hs_active, 1);
        phase_len(1'b0, 4000, n, s, c);
        chk("R10", "next low uses hs counts", n, 12);
        phase_len(1'b1, 4000, n, s, c);
        stop_bus(12);
    endtask

    initial begin
        t_reset();
        t_run("R3 R4 mixed", 16'h0204, 8'd1, 30, 13);
        t_run("minimum", 16'h0000, 8'd0, 1, 0);
        t_run("R3 maximum", 16'h073F, 8'd0, 512, 256);
        t_run("R3 ignored bits", 16'hF8C4, 8'd0, 5, 2);
        t_freeze();
        t_hs();
        t_hs_off(16'h1201);
        t_hs_off(16'h0000);
        t_hs_idle();
        t_boundary();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule